// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches every instruction fetch and data access on a processor core and compares it against four programmable breakpoints. Each breakpoint has a linear address register and a slice of a shared 32-bit control word that selects whether the breakpoint is enabled (through a local and a global enable), what it reacts to (execution, data writes, or any data access) and how wide its watched region is. When an access hits one or more enabled breakpoints, the unit records which breakpoints fired in a sticky status word and raises a one-cycle debug-exception pulse.

A single-step pulse from the core also raises the exception and records its own status flag. A task-switch pulse clears every local enable while leaving the global enables in place, so per-task breakpoints fall away on a context change. Software programs and inspects the unit through a simple select/write/read register port. Address translation and dispatching the exception are left to the surrounding core.

Top module: `dbg_bp_unit`

## Requirements
- R1: After reset every register (the four addresses, control and status) reads as zero and `dbg_exc` is low.
- R2: Register select 0..3 addresses breakpoint addresses 0..3, select 4 the control word and select 5 the status word; `reg_rdata` presents the selected register one cycle after the select is applied. Selects 6 and 7 read as zero and writes to them change nothing. Only status bits 0..3 and 14 exist; other status bits read as zero.
- R3: Breakpoint n takes part in matching only when control bit 2n (local enable) or bit 2n+1 (global enable) is set.
- R4: A `task_switch` pulse clears control bits 0, 2, 4 and 6 and keeps every other control bit; a control write in the same cycle is applied first and its local enables are then cleared.
- R5: Condition 00 (control bits 17+4n:16+4n) matches only a fetch (`acc_kind` 00) whose address equals the breakpoint address exactly, whatever the size field holds.
- R6: Condition 01 matches only writes (`acc_kind` 10); condition 11 matches reads (`acc_kind` 01) and writes; condition 10 never matches; fetches never match a data condition and `acc_kind` 11 never matches anything.
- R7: Size codes (breakpoint field at control bits 19+4n:18+4n and `acc_size`) are 00=1, 01=2, 11=4, 10=8 bytes. A data breakpoint's address is aligned down to its size, and any byte shared between that region and the access region is a match, with no wrap past the top of the address space.
- R8: Status bit n is set in the cycle after breakpoint n matches and stays set until software writes the status word; a write replaces the status, and a match in the same cycle as the write is still recorded.
- R9: A `single_step` pulse sets status bit 14 and raises `dbg_exc` in the following cycle.
- R10: `dbg_exc` is high for exactly the cycle after each cycle that carried a match or a single-step pulse; back-to-back matching accesses give back-to-back pulses.
- R11: When `acc_valid` is low the access inputs are ignored: no status bit is set and no pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for read and write |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Registered read data of the selected register |
| acc_valid | input | 1 | Access on the bus this cycle |
| acc_addr | input | AW | Linear address of the access |
| acc_size | input | 2 | Access width code |
| acc_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 none |
| task_switch | input | 1 | Task-switch event pulse |
| single_step | input | 1 | Single-step event pulse |
| dbg_exc | output | 1 | One-cycle debug-exception pulse |

## Verification
The bench builds the unit with its default parameters: a 32-bit address and four breakpoints, which fills every control field so each condition and size code is reachable in every slot. The 32-bit width lets the bench place a breakpoint in the last word of the address space and drive accesses that end at the top address, where a naive overlap sum would wrap. A randomised phase mixes sizes, kinds, task switches and status clears around the programmed regions, exercising unaligned breakpoint addresses and multiple simultaneous hits.

// File: rtl/dbgbp_pkg.sv
package dbgbp_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10,
    ACC_NONE  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    CND_EXEC  = 2'b00,
    CND_WR    = 2'b01,
    CND_RSVD  = 2'b10,
    CND_RW    = 2'b11
  } bp_cond_e;

  localparam int CTRL_W     = 32;
  localparam int FIELD_BASE = 16;
  localparam int STEP_BIT   = 14;
  localparam int SEL_W      = 3;
  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd4;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd5;

  // Byte count for a size code.
  function automatic logic [3:0] size_len(input logic [1:0] code);
    case (code)
      2'b00:   size_len = 4'd1;
      2'b01:   size_len = 4'd2;
      2'b11:   size_len = 4'd4;
      default: size_len = 4'd8;
    endcase
  endfunction

  // Mask with the local-enable bit of every breakpoint set.
  function automatic logic [CTRL_W-1:0] local_mask(input int nbp);
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int i = 0; i < nbp; i++) m[2*i] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/dbgbp_regs.sv
module dbgbp_regs
  import dbgbp_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NUM_BP = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_we,
  input  logic [SEL_W-1:0]           reg_sel,
  input  logic [AW-1:0]              reg_wdata,
  input  logic                       task_switch,
  output logic [NUM_BP-1:0][AW-1:0]  bp_addr,
  output logic [CTRL_W-1:0]          ctrl
);

  localparam logic [CTRL_W-1:0] LOC_MASK = local_mask(NUM_BP);

  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] ctrl_d;
  logic              ctrl_we;

  assign ctrl_we = reg_we && (reg_sel == SEL_CTRL);

  genvar g;
  generate
    for (g = 0; g < NUM_BP; g++) begin : g_addr
      logic [AW-1:0] addr_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          addr_q <= '0;
        end else if (reg_we && (reg_sel == SEL_W'(g))) begin
          addr_q <= reg_wdata;
        end
      end
      assign bp_addr[g] = addr_q;
    end
  endgenerate

  always_comb begin
    ctrl_d = ctrl_we ? reg_wdata[CTRL_W-1:0] : ctrl_q;
    if (task_switch) ctrl_d = ctrl_d & ~LOC_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

  // R4
  ts_clears_local_chk: assert property (@(posedge clk) disable iff (rst)
    task_switch |=> ((ctrl_q & LOC_MASK) == '0));

  // R4
  ts_keeps_global_chk: assert property (@(posedge clk) disable iff (rst)
    (task_switch && !ctrl_we) |=> ((ctrl_q & ~LOC_MASK) == $past(ctrl_q & ~LOC_MASK)));

endmodule

// File: rtl/dbgbp_cmp.sv
module dbgbp_cmp
  import dbgbp_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic [AW-1:0] acc_addr,
  input  logic [1:0]    acc_size,
  input  logic [1:0]    acc_kind,
  input  logic [AW-1:0] bp_addr,
  input  logic          bp_en,
  input  logic [1:0]    bp_cond,
  input  logic [1:0]    bp_size,
  output logic          hit
);

  logic [3:0]    bp_len;
  logic [3:0]    ac_len;
  logic [AW-1:0] align_mask;
  logic [AW:0]   bp_lo, bp_hi, ac_lo, ac_hi;
  logic          overlap;
  logic          exec_hit;
  logic          data_hit;
  logic          kind_rd, kind_wr;

  always_comb begin
    bp_len     = size_len(bp_size);
    ac_len     = size_len(acc_size);
    align_mask = ~({{(AW-4){1'b0}}, bp_len} - AW'(1));
    bp_lo      = {1'b0, bp_addr & align_mask};
    bp_hi      = bp_lo + {{(AW-3){1'b0}}, bp_len} - (AW+1)'(1);
    ac_lo      = {1'b0, acc_addr};
    ac_hi      = ac_lo + {{(AW-3){1'b0}}, ac_len} - (AW+1)'(1);
    overlap    = (ac_lo <= bp_hi) && (bp_lo <= ac_hi);
    kind_rd    = (acc_kind == ACC_READ);
    kind_wr    = (acc_kind == ACC_WRITE);
    exec_hit   = (bp_cond == CND_EXEC) && (acc_kind == ACC_FETCH) &&
                 (acc_addr == bp_addr);
    data_hit   = overlap &&
                 (((bp_cond == CND_WR) && kind_wr) ||
                  ((bp_cond == CND_RW) && (kind_rd || kind_wr)));
    hit        = acc_valid && bp_en && (exec_hit || data_hit);
  end

  // R6
  rsvd_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (bp_cond == CND_RSVD) |-> !hit);

  // R6
  none_kind_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == ACC_NONE) |-> !hit);

endmodule

// File: rtl/dbgbp_status.sv
module dbgbp_status
  import dbgbp_pkg::*;
#(
  parameter int NUM_BP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              st_we,
  input  logic [NUM_BP-1:0] st_wbits,
  input  logic              st_wstep,
  input  logic [NUM_BP-1:0] hit_in,
  input  logic              single_step,
  output logic [NUM_BP-1:0] st_hits,
  output logic              st_step,
  output logic              dbg_exc
);

  logic [NUM_BP-1:0] hits_q, hits_d;
  logic              step_q, step_d;
  logic              exc_q;

  always_comb begin
    hits_d = st_we ? st_wbits : hits_q;
    step_d = st_we ? st_wstep : step_q;
    hits_d = hits_d | hit_in;
    step_d = step_d | single_step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hits_q <= '0;
      step_q <= 1'b0;
      exc_q  <= 1'b0;
    end else begin
      hits_q <= hits_d;
      step_q <= step_d;
      exc_q  <= (|hit_in) || single_step;
    end
  end

  assign st_hits = hits_q;
  assign st_step = step_q;
  assign dbg_exc = exc_q;

  // R8
  sticky_hits_chk: assert property (@(posedge clk) disable iff (rst)
    !st_we |=> ((hits_q & $past(hits_q)) == $past(hits_q)));

  // R9
  step_flag_chk: assert property (@(posedge clk) disable iff (rst)
    single_step |=> (step_q && exc_q));

  // R10
  exc_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (|hit_in) |=> exc_q);

endmodule

// File: rtl/dbg_bp_unit.sv
module dbg_bp_unit
  import dbgbp_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NUM_BP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [2:0]       reg_sel,
  input  logic [AW-1:0]    reg_wdata,
  output logic [AW-1:0]    reg_rdata,
  input  logic             acc_valid,
  input  logic [AW-1:0]    acc_addr,
  input  logic [1:0]       acc_size,
  input  logic [1:0]       acc_kind,
  input  logic             task_switch,
  input  logic             single_step,
  output logic             dbg_exc
);

  logic [NUM_BP-1:0][AW-1:0] bp_addr;
  logic [CTRL_W-1:0]         ctrl;
  logic [NUM_BP-1:0]         hit;
  logic [NUM_BP-1:0]         st_hits;
  logic                      st_step;
  logic                      st_we;
  logic [AW-1:0]             rd_mux;
  logic [AW-1:0]             rdata_q;

  initial begin
    if (AW != CTRL_W) $error("AW must equal the control word width");
    if (NUM_BP < 1 || NUM_BP > 4) $error("NUM_BP must be 1..4");
  end

  dbgbp_regs #(.AW(AW), .NUM_BP(NUM_BP)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_sel     (reg_sel),
    .reg_wdata   (reg_wdata),
    .task_switch (task_switch),
    .bp_addr     (bp_addr),
    .ctrl        (ctrl)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_BP; g++) begin : g_cmp
      dbgbp_cmp #(.AW(AW)) u_cmp (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .acc_kind  (acc_kind),
        .bp_addr   (bp_addr[g]),
        .bp_en     (ctrl[2*g] | ctrl[2*g+1]),
        .bp_cond   (ctrl[FIELD_BASE+4*g +: 2]),
        .bp_size   (ctrl[FIELD_BASE+4*g+2 +: 2]),
        .hit       (hit[g])
      );
    end
  endgenerate

  assign st_we = reg_we && (reg_sel == SEL_STAT);

  dbgbp_status #(.NUM_BP(NUM_BP)) u_status (
    .clk         (clk),
    .rst         (rst),
    .st_we       (st_we),
    .st_wbits    (reg_wdata[NUM_BP-1:0]),
    .st_wstep    (reg_wdata[STEP_BIT]),
    .hit_in      (hit),
    .single_step (single_step),
    .st_hits     (st_hits),
    .st_step     (st_step),
    .dbg_exc     (dbg_exc)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_sel == SEL_CTRL) begin
      rd_mux = ctrl;
    end else if (reg_sel == SEL_STAT) begin
      rd_mux[NUM_BP-1:0] = st_hits;
      rd_mux[STEP_BIT]   = st_step;
    end else begin
      for (int i = 0; i < NUM_BP; i++)
        if (reg_sel == SEL_W'(i)) rd_mux = bp_addr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;

  // R11
  idle_no_exc_chk: assert property (@(posedge clk) disable iff (rst)
    (!acc_valid && !single_step) |=> !dbg_exc);

  // R3
  disabled_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    ((ctrl & local_mask(NUM_BP)) == '0 && (ctrl & (local_mask(NUM_BP) << 1)) == '0)
      |-> (hit == '0));

endmodule

// File: tb/dbg_bp_unit_tb.sv
module dbg_bp_unit_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          reg_we;
  logic [2:0]    reg_sel;
  logic [AW-1:0] reg_wdata;
  logic [AW-1:0] reg_rdata;
  logic          acc_valid;
  logic [AW-1:0] acc_addr;
  logic [1:0]    acc_size;
  logic [1:0]    acc_kind;
  logic          task_switch;
  logic          single_step;
  logic          dbg_exc;

  int     n_tests = 0;
  int     n_fail  = 0;
  int     cycles  = 0;
  string  cur_tag = "R1";
  bit     done    = 0;

  // behavioural model state
  longint unsigned m_bp[4];
  longint unsigned m_ctrl;
  longint unsigned m_stat;
  bit              m_exc;
  longint unsigned m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_bp_unit #(.AW(AW), .NUM_BP(4)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_kind(acc_kind),
    .task_switch(task_switch), .single_step(single_step), .dbg_exc(dbg_exc)
  );

  function automatic int nbytes(int code);
    case (code)
      0: return 1;
      1: return 2;
      3: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic bit model_hit(int n, longint unsigned a, int sz, int kind);
    int cond, bsz, blen, alen;
    longint unsigned base;
    bit en;
    cond = int'((m_ctrl >> (16 + 4*n)) & 3);
    bsz  = int'((m_ctrl >> (18 + 4*n)) & 3);
    en   = ((m_ctrl >> (2*n)) & 3) != 0;
    if (!en || kind == 3) return 0;
    if (cond == 0) return (kind == 0) && (a == m_bp[n]);
    if (cond == 2 || kind == 0) return 0;
    if (cond == 1 && kind != 2) return 0;
    blen = nbytes(bsz);
    alen = nbytes(sz);
    base = m_bp[n] - (m_bp[n] % longint'(blen));
    for (int i = 0; i < alen; i++) begin
      longint unsigned b;
      b = a + longint'(i);
      if (b >= base && b < base + longint'(blen)) return 1;
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) m_bp[i] = 0;
      m_ctrl = 0; m_stat = 0; m_exc = 0; m_rdata = 0;
    end else begin
      longint unsigned hits;
      hits = 0;
      case (reg_sel)
        3'd0, 3'd1, 3'd2, 3'd3: m_rdata = m_bp[reg_sel];
        3'd4:    m_rdata = m_ctrl;
        3'd5:    m_rdata = m_stat;
        default: m_rdata = 0;
      endcase
      if (acc_valid)
        for (int i = 0; i < 4; i++)
          if (model_hit(i, acc_addr, acc_size, acc_kind)) hits |= (64'd1 << i);
      m_exc = (hits != 0) || single_step;
      if (reg_we) begin
        if (reg_sel < 3'd4) m_bp[reg_sel] = reg_wdata;
        else if (reg_sel == 3'd4) m_ctrl = reg_wdata;
        else if (reg_sel == 3'd5) m_stat = reg_wdata & 32'h0000_400F;
      end
      if (task_switch) m_ctrl = m_ctrl & ~64'h55;
      m_stat = m_stat | hits | (single_step ? 64'h4000 : 64'h0);
    end
  end

  task automatic check(input string tag, input longint unsigned act, input longint unsigned exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (!rst && !done) begin
      check({cur_tag, " exc"}, dbg_exc, m_exc);
      check({cur_tag, " rdata"}, reg_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_sel = s;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic acc(input logic [31:0] a, input logic [1:0] sz, input logic [1:0] k, output logic e);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_kind = k;
    @(negedge clk);
    acc_valid = 1'b0;
    e = dbg_exc;
  endtask

  function automatic logic [31:0] cfg(int n, bit le, bit ge, int cond, int sz);
    logic [31:0] c;
    c = '0;
    c[2*n] = le; c[2*n+1] = ge;
    c[16+4*n +: 2] = 2'(cond);
    c[18+4*n +: 2] = 2'(sz);
    return c;
  endfunction

  initial begin
    logic [31:0] d;
    logic e;
    rst = 1'b1; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    acc_valid = 0; acc_addr = 0; acc_size = 0; acc_kind = 0;
    task_switch = 0; single_step = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    cur_tag = "R1";
    check("R1 exc", dbg_exc, 0);
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), d);
      check("R1 reg", d, 0);
    end

    // R2 register port
    cur_tag = "R2";
    wr(0, 32'h0000_1000); wr(1, 32'h0000_2000); wr(2, 32'h0000_3005); wr(3, 32'hFFFF_FFFC);
    rd(2, d); check("R2 addr2", d, 32'h0000_3005);
    wr(6, 32'hDEAD_BEEF);
    rd(6, d); check("R2 sel6 zero", d, 0);
    rd(0, d); check("R2 sel6 no effect", d, 32'h0000_1000);
    wr(5, 32'hFFFF_FFFF);
    rd(5, d); check("R2 status mask", d, 32'h0000_400F);
    wr(5, 0);

    // R3 enables
    cur_tag = "R3";
    wr(4, cfg(0, 0, 0, 0, 0));
    acc(32'h1000, 0, 0, e); check("R3 disabled", e, 0);
    wr(4, cfg(0, 1, 0, 0, 0));
    acc(32'h1000, 0, 0, e); check("R3 local en", e, 1);
    rd(5, d); check("R3 status bit0", d, 1);

    // R5 execution condition
    cur_tag = "R5";
    wr(5, 0);
    acc(32'h1001, 0, 0, e); check("R5 off by one", e, 0);
    acc(32'h1000, 0, 1, e); check("R5 read on exec", e, 0);
    wr(4, cfg(0, 1, 0, 0, 3));
    acc(32'h1002, 0, 0, e); check("R5 size ignored", e, 0);

    // R6 data conditions
    cur_tag = "R6";
    wr(4, cfg(1, 0, 1, 1, 3));
    acc(32'h2002, 0, 2, e); check("R6 wr on cond01", e, 1);
    acc(32'h2002, 0, 1, e); check("R6 rd on cond01", e, 0);
    acc(32'h2000, 0, 0, e); check("R6 fetch on data", e, 0);
    wr(4, cfg(1, 0, 1, 3, 3));
    acc(32'h2001, 0, 1, e); check("R6 rd on cond11", e, 1);
    acc(32'h2001, 0, 3, e); check("R6 kind none", e, 0);
    wr(4, cfg(1, 0, 1, 2, 3));
    acc(32'h2000, 0, 2, e); check("R6 cond10", e, 0);

    // R7 size, alignment, overlap
    cur_tag = "R7";
    wr(4, cfg(2, 0, 1, 3, 2));
    acc(32'h2FFE, 3, 2, e); check("R7 overlap low", e, 1);
    acc(32'h3008, 0, 2, e); check("R7 past end", e, 0);
    acc(32'h2FFC, 3, 2, e); check("R7 below base", e, 0);
    acc(32'h3000, 0, 1, e); check("R7 aligned base", e, 1);
    wr(4, cfg(3, 0, 1, 3, 3));
    acc(32'hFFFF_FFFF, 0, 1, e); check("R7 top byte", e, 1);
    acc(32'hFFFF_FFFE, 1, 1, e); check("R7 top half", e, 1);
    acc(32'hFFFF_FFFB, 0, 1, e); check("R7 below top", e, 0);
    acc(32'hFFFF_FFF8, 3, 1, e); check("R7 no wrap", e, 0);

    // R8 sticky status
    cur_tag = "R8";
    wr(5, 0);
    rd(5, d); check("R8 cleared", d, 0);
    acc(32'hFFFF_FFFD, 0, 2, e);
    acc(32'h0000_0100, 0, 2, e);
    rd(5, d); check("R8 sticky", d, 32'h8);
    @(negedge clk);
    reg_we = 1; reg_sel = 5; reg_wdata = 0;
    acc_valid = 1; acc_addr = 32'hFFFF_FFFC; acc_size = 0; acc_kind = 1;
    @(negedge clk);
    reg_we = 0; acc_valid = 0;
    rd(5, d); check("R8 write vs hit", d, 32'h8);

    // R9 single step
    cur_tag = "R9";
    wr(5, 0);
    @(negedge clk); single_step = 1;
    @(negedge clk); single_step = 0;
    check("R9 exc", dbg_exc, 1);
    rd(5, d); check("R9 step flag", d, 32'h4000);

    // R4 task switch
    cur_tag = "R4";
    wr(4, 32'h00F0_00FF);
    @(negedge clk); task_switch = 1;
    @(negedge clk); task_switch = 0;
    rd(4, d); check("R4 locals cleared", d, 32'h00F0_00AA);
    @(negedge clk); reg_we = 1; reg_sel = 4; reg_wdata = 32'h0000_00FF; task_switch = 1;
    @(negedge clk); reg_we = 0; task_switch = 0;
    rd(4, d); check("R4 write then clear", d, 32'h0000_00AA);

    // R10 pulse shape
    cur_tag = "R10";
    wr(4, cfg(3, 0, 1, 3, 3));
    @(negedge clk); acc_valid = 1; acc_addr = 32'hFFFF_FFFC; acc_size = 0; acc_kind = 2;
    @(negedge clk); check("R10 first pulse", dbg_exc, 1);
    @(negedge clk); check("R10 second pulse", dbg_exc, 1);
    acc_addr = 32'h10;
    @(negedge clk); check("R10 pulse ends", dbg_exc, 0);
    acc_valid = 0;

    // R11 invalid access ignored
    cur_tag = "R11";
    wr(5, 0);
    @(negedge clk); acc_valid = 0; acc_addr = 32'hFFFF_FFFC; acc_kind = 2;
    @(negedge clk); check("R11 no exc", dbg_exc, 0);
    rd(5, d); check("R11 no status", d, 0);

    // randomised mix against the model
    cur_tag = "R7";
    wr(0, 32'h0000_4003); wr(1, 32'h0000_4010); wr(2, 32'h0000_401E); wr(3, 32'h0000_4007);
    wr(4, 32'hE7B1_00C9);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      acc_valid   = ($urandom_range(0, 3) != 0);
      acc_addr    = 32'h4000 + $urandom_range(0, 40);
      acc_size    = 2'($urandom_range(0, 3));
      acc_kind    = 2'($urandom_range(0, 3));
      single_step = ($urandom_range(0, 31) == 0);
      task_switch = ($urandom_range(0, 63) == 0);
      reg_sel     = 3'($urandom_range(0, 7));
      reg_we      = ($urandom_range(0, 31) == 0) && (reg_sel == 3'd5);
      reg_wdata   = $urandom;
      if ($urandom_range(0, 99) == 0) begin
        reg_we = 1; reg_sel = 4; reg_wdata = $urandom | 32'hFF;
      end
    end
    @(negedge clk);
    acc_valid = 0; single_step = 0; task_switch = 0; reg_we = 0;
    @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    done = 1;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule